// File: doc/BRIEF.md
# Whole-Register Transfer Sequencer

This block walks through the element accesses of a vector load or store that moves whole registers, or one mask register, in one instruction. A start command gives the base address, the first destination or source register, a field count, an element width code, the resume index and the vector length. The sequencer then presents one element request per handshake. Each request carries a byte address, a register number and an element slot within that register. A progress register always holds the global index of the element being requested.

A whole-register move covers nf registers. Each register holds VLEN / (8 * element_bytes) elements. The move ignores vl and masking. A mask move uses byte elements in a single register and stops after ceil(vl / 8) bytes. A nonzero resume index is split into a starting register and a starting slot, so an interrupted transfer can carry on where it stopped. A memory fault reported on a handshake, or a base address that is misaligned for the element width, ends the command. The progress register is then left at the element that failed. A command that completes clears the progress register to zero.

Top module: `wreg_xfer_seq`

## Requirements
- R1: In the whole-register modes, the field-count code gives a count of code+1. Only codes 0, 1, 3 and 7 (counts 1, 2, 4, 8) are legal. Any other code raises `illegal_o` for one cycle, one clock after start. No request is issued and `vstart_o` keeps its prior value.
- R2: A register holds VLEN/(8*B) elements, where B is the element size in bytes. After the element in the last slot, the next request goes to slot 0 of the next register number, modulo 32.
- R3: If the resume index is at least the total element count, no request is issued. `done_o` pulses one clock after start and `vstart_o` becomes 0.
- R4: For a whole-register move resumed at index v, the first request targets register base_reg + v / EPR at slot v % EPR, where EPR is the number of elements per register.
- R5: The request for global element k has address base + k*B and `req_size_o` = log2(B). `vstart_o` equals k while that request is presented.
- R6: Whole-register store (mode 1) always moves 1-byte elements (`req_size_o` = 0), whatever the width code. Whole-register load (mode 0) uses B = 2^width_code.
- R7: The mask modes (2 = load, 3 = store) move bytes in the single register `base_reg_i`, at slot k, for k from the resume index up to ceil(vl/8) - 1. The field-count and width codes are ignored in these modes.
- R8: If the base address is not a multiple of B and the command is not empty, no request is issued. `fault_o` pulses one clock after start and `vstart_o` holds the resume index.
- R9: If `req_fault_i` is high on a handshake, the command stops. `fault_o` pulses in the next cycle, `busy_o` drops and `vstart_o` keeps the failing index.
- R10: One clock after the handshake of the last element, `done_o` pulses, `busy_o` drops and `vstart_o` is 0.
- R11: While `req_valid_o` is high and `req_ready_i` is low, the request payload and `vstart_o` stay unchanged.
- R12: A start pulse while the block is busy is ignored.
- R13: A whole-register move issues exactly nf*EPR minus v requests, whatever `vl_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a command (taken only while idle) |
| mode_i | input | 2 | 0 whole load, 1 whole store, 2 mask load, 3 mask store |
| nf_code_i | input | 3 | Field count minus one |
| eew_code_i | input | 2 | Element width code, B = 2^code bytes |
| base_addr_i | input | ADDR_W | Byte address of element 0 |
| base_reg_i | input | 5 | First register of the group |
| vstart_i | input | VS_W | Resume index |
| vl_i | input | VS_W | Vector length (used by mask modes only) |
| busy_o | output | 1 | A command is in progress |
| req_valid_o | output | 1 | Element request valid |
| req_ready_i | input | 1 | Element request accepted |
| req_fault_i | input | 1 | Accepted request faulted |
| req_addr_o | output | ADDR_W | Element byte address |
| req_reg_o | output | 5 | Register number |
| req_slot_o | output | SLOT_W | Element slot inside the register |
| req_size_o | output | 2 | log2 of element bytes |
| vstart_o | output | VS_W | Progress register |
| done_o | output | 1 | Command completed (pulse) |
| fault_o | output | 1 | Command aborted on a fault (pulse) |
| illegal_o | output | 1 | Command rejected (pulse) |

## Verification
The assertions assume that `req_fault_i` only matters when a handshake happens. They also assume that in the mask modes vl never exceeds VLEN, so the byte count fits in one register. The stimulus draws mask lengths no larger than VLEN and resume indices at most two past the total. It raises the fault input only on a single chosen element of a command. Misaligned bases, illegal field codes and starts while busy are driven on purpose, because the block must handle all three.

// File: rtl/wrx_pkg.sv
package wrx_pkg;

    typedef enum logic [1:0] {
        XM_REG_LOAD   = 2'd0,
        XM_REG_STORE  = 2'd1,
        XM_MASK_LOAD  = 2'd2,
        XM_MASK_STORE = 2'd3
    } xfer_mode_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    function automatic logic mode_is_mask(xfer_mode_e m);
        return (m == XM_MASK_LOAD) || (m == XM_MASK_STORE);
    endfunction

    // Field counts 1, 2, 4 and 8 only
    function automatic logic nf_code_ok(logic [2:0] c);
        return (c == 3'd0) || (c == 3'd1) || (c == 3'd3) || (c == 3'd7);
    endfunction

endpackage

// File: rtl/wrx_plan.sv
// Decodes a start command into element size, per-register count,
// total element count and the resume position.
module wrx_plan
    import wrx_pkg::*;
#(
    parameter int VLENB_LOG2 = 4,
    parameter int SLOT_W     = 4,
    parameter int VS_W       = 16,
    parameter int ADDR_W     = 32,
    parameter int REG_W      = 5
) (
    input  xfer_mode_e          mode_i,
    input  logic [2:0]          nf_code_i,
    input  logic [1:0]          eew_code_i,
    input  logic [ADDR_W-1:0]   base_addr_i,
    input  logic [REG_W-1:0]    base_reg_i,
    input  logic [VS_W-1:0]     vstart_i,
    input  logic [VS_W-1:0]     vl_i,
    output logic                legal_o,
    output logic                misalign_o,
    output logic                empty_o,
    output logic                mask_o,
    output logic [1:0]          size_o,
    output logic [7:0]          epr_log2_o,
    output logic [VS_W:0]       total_o,
    output logic [REG_W-1:0]    first_reg_o,
    output logic [SLOT_W-1:0]   first_slot_o
);

    logic [3:0]       nf_count;
    logic [2:0]       align_bits;
    logic [VS_W-1:0]  slot_mask;

    always_comb begin
        mask_o   = mode_is_mask(mode_i);
        size_o   = (mode_i == XM_REG_LOAD) ? eew_code_i : 2'd0;
        legal_o  = mask_o || nf_code_ok(nf_code_i);
        nf_count = {1'b0, nf_code_i} + 4'd1;

        epr_log2_o = 8'(VLENB_LOG2) - {6'd0, size_o};

        if (mask_o) begin
            total_o = ({1'b0, vl_i} + (VS_W+1)'(7)) >> 3;
        end else begin
            total_o = (VS_W+1)'(nf_count) << epr_log2_o;
        end

        empty_o = ({1'b0, vstart_i} >= total_o);

        case (size_o)
            2'd0:    align_bits = 3'b000;
            2'd1:    align_bits = 3'b001;
            2'd2:    align_bits = 3'b011;
            default: align_bits = 3'b111;
        endcase
        misalign_o = |(base_addr_i[2:0] & align_bits);

        slot_mask = (VS_W'(1) << epr_log2_o) - VS_W'(1);
        if (mask_o) begin
            first_reg_o  = base_reg_i;
            first_slot_o = SLOT_W'(vstart_i);
        end else begin
            first_reg_o  = base_reg_i + REG_W'(vstart_i >> epr_log2_o);
            first_slot_o = SLOT_W'(vstart_i & slot_mask);
        end
    end

endmodule

// File: rtl/wrx_addr.sv
// Byte address of global element k: base + k * 2^size.
module wrx_addr #(
    parameter int ADDR_W = 32,
    parameter int VS_W   = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [VS_W-1:0]   k_i,
    input  logic [1:0]        size_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] k_ext;

    generate
        if (ADDR_W >= VS_W) begin : g_wide
            assign k_ext = ADDR_W'(k_i);
        end else begin : g_narrow
            assign k_ext = k_i[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        addr_o = base_i + (k_ext << size_i);
    end

endmodule

// File: rtl/wrx_step.sv
// Advances the slot and register pair by one element.
module wrx_step #(
    parameter int SLOT_W = 4,
    parameter int REG_W  = 5
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [7:0]        epr_log2_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [REG_W-1:0]  reg_o
);

    logic [SLOT_W:0] epr_cnt;
    logic [SLOT_W:0] slot_inc;

    always_comb begin
        epr_cnt  = (SLOT_W+1)'(1) << epr_log2_i;
        slot_inc = {1'b0, slot_i} + (SLOT_W+1)'(1);
        if (slot_inc == epr_cnt) begin
            slot_o = '0;
            reg_o  = reg_i + REG_W'(1);
        end else begin
            slot_o = slot_inc[SLOT_W-1:0];
            reg_o  = reg_i;
        end
    end

endmodule

// File: rtl/wreg_xfer_seq.sv
module wreg_xfer_seq
    import wrx_pkg::*;
#(
    parameter  int VLEN       = 128,
    parameter  int ADDR_W     = 32,
    parameter  int VS_W       = 16,
    localparam int REG_W      = 5,
    localparam int VLENB      = VLEN / 8,
    localparam int VLENB_LOG2 = $clog2(VLENB),
    localparam int SLOT_W     = (VLENB_LOG2 < 1) ? 1 : VLENB_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [2:0]        nf_code_i,
    input  logic [1:0]        eew_code_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [REG_W-1:0]  base_reg_i,
    input  logic [VS_W-1:0]   vstart_i,
    input  logic [VS_W-1:0]   vl_i,
    output logic              busy_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    input  logic              req_fault_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [REG_W-1:0]  req_reg_o,
    output logic [SLOT_W-1:0] req_slot_o,
    output logic [1:0]        req_size_o,
    output logic [VS_W-1:0]   vstart_o,
    output logic              done_o,
    output logic              fault_o,
    output logic              illegal_o
);

    typedef struct packed {
        seq_state_e          state;
        logic [1:0]          size;
        logic [7:0]          epr_log2;
        logic [VS_W:0]       total;
        logic [ADDR_W-1:0]   base;
        logic [REG_W-1:0]    rnum;
        logic [SLOT_W-1:0]   slot;
        logic [VS_W-1:0]     k;
        logic                done;
        logic                fault;
        logic                illegal;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              p_legal, p_misalign, p_empty, p_mask;
    logic [1:0]        p_size;
    logic [7:0]        p_epr_log2;
    logic [VS_W:0]     p_total;
    logic [REG_W-1:0]  p_reg;
    logic [SLOT_W-1:0] p_slot;
    logic [SLOT_W-1:0] nx_slot;
    logic [REG_W-1:0]  nx_reg;
    logic [ADDR_W-1:0] cur_addr;

    wrx_plan #(
        .VLENB_LOG2 (VLENB_LOG2),
        .SLOT_W     (SLOT_W),
        .VS_W       (VS_W),
        .ADDR_W     (ADDR_W),
        .REG_W      (REG_W)
    ) u_plan (
        .mode_i       (xfer_mode_e'(mode_i)),
        .nf_code_i    (nf_code_i),
        .eew_code_i   (eew_code_i),
        .base_addr_i  (base_addr_i),
        .base_reg_i   (base_reg_i),
        .vstart_i     (vstart_i),
        .vl_i         (vl_i),
        .legal_o      (p_legal),
        .misalign_o   (p_misalign),
        .empty_o      (p_empty),
        .mask_o       (p_mask),
        .size_o       (p_size),
        .epr_log2_o   (p_epr_log2),
        .total_o      (p_total),
        .first_reg_o  (p_reg),
        .first_slot_o (p_slot)
    );

    wrx_step #(
        .SLOT_W (SLOT_W),
        .REG_W  (REG_W)
    ) u_step (
        .slot_i     (seq_q.slot),
        .reg_i      (seq_q.rnum),
        .epr_log2_i (seq_q.epr_log2),
        .slot_o     (nx_slot),
        .reg_o      (nx_reg)
    );

    wrx_addr #(
        .ADDR_W (ADDR_W),
        .VS_W   (VS_W)
    ) u_addr (
        .base_i (seq_q.base),
        .k_i    (seq_q.k),
        .size_i (seq_q.size),
        .addr_o (cur_addr)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.done    = 1'b0;
        seq_d.fault   = 1'b0;
        seq_d.illegal = 1'b0;

        case (seq_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    if (!p_legal) begin
                        seq_d.illegal = 1'b1;
                    end else if (p_empty) begin
                        seq_d.done = 1'b1;
                        seq_d.k    = '0;
                    end else if (p_misalign) begin
                        seq_d.fault = 1'b1;
                        seq_d.k     = vstart_i;
                    end else begin
                        seq_d.state    = SQ_RUN;
                        seq_d.size     = p_size;
                        seq_d.epr_log2 = p_mask ? 8'(VLENB_LOG2) : p_epr_log2;
                        seq_d.total    = p_total;
                        seq_d.base     = base_addr_i;
                        seq_d.rnum     = p_reg;
                        seq_d.slot     = p_slot;
                        seq_d.k        = vstart_i;
                    end
                end
            end
            default: begin
                if (req_ready_i) begin
                    if (req_fault_i) begin
                        seq_d.fault = 1'b1;
                        seq_d.state = SQ_IDLE;
                    end else if (({1'b0, seq_q.k} + (VS_W+1)'(1)) == seq_q.total) begin
                        seq_d.done  = 1'b1;
                        seq_d.k     = '0;
                        seq_d.state = SQ_IDLE;
                    end else begin
                        seq_d.k    = seq_q.k + VS_W'(1);
                        seq_d.slot = nx_slot;
                        seq_d.rnum = nx_reg;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o      = (seq_q.state == SQ_RUN);
    assign req_valid_o = (seq_q.state == SQ_RUN);
    assign req_addr_o  = cur_addr;
    assign req_reg_o   = seq_q.rnum;
    assign req_slot_o  = seq_q.slot;
    assign req_size_o  = seq_q.size;
    assign vstart_o    = seq_q.k;
    assign done_o      = seq_q.done;
    assign fault_o     = seq_q.fault;
    assign illegal_o   = seq_q.illegal;

endmodule

// File: rtl/wrx_chk.sv
module wrx_chk #(
    parameter int ADDR_W     = 32,
    parameter int VS_W       = 16,
    parameter int REG_W      = 5,
    parameter int SLOT_W     = 4,
    parameter int VLENB_LOG2 = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic              req_fault_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [REG_W-1:0]  req_reg_o,
    input logic [SLOT_W-1:0] req_slot_o,
    input logic [1:0]        req_size_o,
    input logic [VS_W-1:0]   vstart_o,
    input logic              done_o,
    input logic              fault_o,
    input logic              illegal_o
);

    assert_hold_payload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)
            && $stable(req_reg_o) && $stable(req_slot_o) && $stable(vstart_o)));

    assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (vstart_o == '0 && !busy_o));

    assert_single_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fault_o, illegal_o}));

    assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!busy_o && !req_valid_o));

    assert_progress_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i && !req_fault_i) |=>
            (done_o || (vstart_o == $past(vstart_o) + VS_W'(1))));

    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> ({1'b0, req_slot_o} <
            ((SLOT_W+1)'(1) << (VLENB_LOG2 - int'(req_size_o)))));

    assert_abort_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i && req_fault_i) |=>
            (fault_o && !busy_o && vstart_o == $past(vstart_o)));

    assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !req_ready_i) |=> (busy_o && $stable(vstart_o)));

endmodule

bind wreg_xfer_seq wrx_chk #(
    .ADDR_W     (ADDR_W),
    .VS_W       (VS_W),
    .REG_W      (REG_W),
    .SLOT_W     (SLOT_W),
    .VLENB_LOG2 (VLENB_LOG2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_fault_i (req_fault_i),
    .req_addr_o  (req_addr_o),
    .req_reg_o   (req_reg_o),
    .req_slot_o  (req_slot_o),
    .req_size_o  (req_size_o),
    .vstart_o    (vstart_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .illegal_o   (illegal_o)
);

// File: tb/sim_wreg_xfer_seq.sv
`timescale 1ns/1ps
module sim_wreg_xfer_seq;

    localparam int VLEN   = 128;
    localparam int VLENB  = VLEN / 8;
    localparam int ADDR_W = 32;
    localparam int VS_W   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [2:0]  nf_code_i = '0;
    logic [1:0]  eew_code_i = '0;
    logic [31:0] base_addr_i = '0;
    logic [4:0]  base_reg_i = '0;
    logic [15:0] vstart_i = '0;
    logic [15:0] vl_i = '0;
    logic        busy_o, req_valid_o;
    logic        req_ready_i = 1'b0;
    logic        req_fault_i = 1'b0;
    logic [31:0] req_addr_o;
    logic [4:0]  req_reg_o;
    logic [3:0]  req_slot_o;
    logic [1:0]  req_size_o;
    logic [15:0] vstart_o;
    logic        done_o, fault_o, illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    int prog     = 0;

    always #5 clk = ~clk;

    wreg_xfer_seq #(.VLEN(VLEN), .ADDR_W(ADDR_W), .VS_W(VS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .nf_code_i(nf_code_i), .eew_code_i(eew_code_i), .base_addr_i(base_addr_i),
        .base_reg_i(base_reg_i), .vstart_i(vstart_i), .vl_i(vl_i),
        .busy_o(busy_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_fault_i(req_fault_i), .req_addr_o(req_addr_o), .req_reg_o(req_reg_o),
        .req_slot_o(req_slot_o), .req_size_o(req_size_o), .vstart_o(vstart_o),
        .done_o(done_o), .fault_o(fault_o), .illegal_o(illegal_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int size_of(int mode, int eew);
        return (mode == 0) ? eew : 0;
    endfunction

    function automatic int epr_of(int sz);
        return VLENB >> sz;
    endfunction

    function automatic bit legal_of(int mode, int nf);
        return (mode >= 2) || nf == 0 || nf == 1 || nf == 3 || nf == 7;
    endfunction

    function automatic int total_of(int mode, int nf, int eew, int vl);
        if (mode >= 2) return (vl + 7) / 8;
        return (nf + 1) * epr_of(size_of(mode, eew));
    endfunction

    // Runs one command; starts and ends on a falling edge.
    task automatic run_cmd(input int mode, input int nf, input int eew,
                           input logic [31:0] base, input int breg,
                           input int vs, input int vl, input int fault_at,
                           input bit poke, input string end_tag);
        int sz, epr, total, k, ereg, eslot;
        longint eaddr, act, exp;
        bit stalled, rdy, fl;
        string tag;
        mode_i = mode[1:0]; nf_code_i = nf[2:0]; eew_code_i = eew[1:0];
        base_addr_i = base; base_reg_i = breg[4:0];
        vstart_i = vs[15:0]; vl_i = vl[15:0]; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        sz = size_of(mode, eew);
        epr = epr_of(sz);
        total = total_of(mode, nf, eew, vl);
        if (!legal_of(mode, nf)) begin
            check(illegal_o && !busy_o, "R1", "illegal pulse/busy", {illegal_o, busy_o}, 2);
            check(vstart_o == 16'(prog), "R1", "progress kept", vstart_o, prog);
            @(negedge clk);
            return;
        end
        if (vs >= total) begin
            check(done_o && !busy_o && vstart_o == 0, "R3", "empty command",
                  {done_o, busy_o, vstart_o}, 64'h2_0000);
            prog = 0;
            @(negedge clk);
            return;
        end
        if ((base & ((32'd1 << sz) - 1)) != 0) begin
            check(fault_o && !req_valid_o && vstart_o == 16'(vs), "R8", "misaligned abort",
                  {fault_o, req_valid_o, vstart_o}, {2'b10, 16'(vs)});
            prog = vs;
            @(negedge clk);
            return;
        end
        k = vs;
        stalled = 1'b0;
        while (1) begin
            if (!req_valid_o) begin
                check(1'b0, end_tag, "request missing", k, total);
                return;
            end
            ereg  = (mode >= 2) ? breg : ((breg + k / epr) & 31);
            eslot = (mode >= 2) ? k : (k % epr);
            eaddr = longint'(base) + (longint'(k) << sz);
            eaddr = eaddr & 64'hFFFF_FFFF;
            if (mode >= 2) tag = "R7";
            else if (mode == 1) tag = "R6";
            else if (stalled) tag = "R11";
            else if (k == vs && vs != 0) tag = "R4";
            else if (eslot == 0 && k != vs) tag = "R2";
            else tag = "R5";
            act = {req_addr_o, req_reg_o, req_slot_o, req_size_o, vstart_o};
            exp = {eaddr[31:0], 5'(ereg), 4'(eslot), 2'(sz), 16'(k)};
            check(act == exp, tag, "request payload", act, exp);
            rdy = ($urandom % 3) != 0;
            fl  = rdy && (k == fault_at);
            if (poke && k == vs + 1) begin
                start_i = 1'b1; mode_i = 2'd2; base_reg_i = 5'd9; vstart_i = 16'd0; vl_i = 16'd8;
            end
            req_ready_i = rdy;
            req_fault_i = fl;
            @(negedge clk);
            start_i = 1'b0; req_ready_i = 1'b0; req_fault_i = 1'b0;
            stalled = !rdy;
            if (rdy) begin
                if (fl) begin
                    check(fault_o && !busy_o && vstart_o == 16'(k), "R9", "fault abort",
                          {fault_o, busy_o, vstart_o}, {2'b10, 16'(k)});
                    prog = k;
                    @(negedge clk);
                    return;
                end
                k++;
                if (k == total) begin
                    check(done_o && !busy_o && vstart_o == 0, end_tag, "completion",
                          {done_o, busy_o, vstart_o}, 64'h2_0000);
                    prog = 0;
                    @(negedge clk);
                    return;
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !req_valid_o && vstart_o == 0 && !done_o && !fault_o && !illegal_o,
              "R10", "reset state", {busy_o, req_valid_o, vstart_o}, 0);

        // Directed corners
        run_cmd(0, 2, 0, 32'h100, 4, 0, 0, -1, 0, "R1");           // illegal count 3
        run_cmd(0, 0, 2, 32'h200, 2, 4, 0, -1, 0, "R3");           // vstart == total
        run_cmd(2, 5, 3, 32'h300, 3, 0, 0, -1, 0, "R3");           // mask, vl = 0
        run_cmd(0, 1, 1, 32'h400, 6, 5, 0, -1, 0, "R4");           // resume mid-register
        run_cmd(0, 3, 2, 32'h500, 8, 6, 0, -1, 0, "R2");           // crosses registers
        run_cmd(1, 0, 3, 32'h601, 1, 0, 0, -1, 0, "R6");           // store: byte, odd base ok
        run_cmd(2, 6, 2, 32'h700, 10, 1, 17, -1, 0, "R7");         // mask load, 3 bytes
        run_cmd(3, 2, 1, 32'h703, 11, 0, 128, -1, 0, "R7");        // mask store, full
        run_cmd(0, 0, 2, 32'h1002, 4, 1, 0, -1, 0, "R8");          // misaligned
        run_cmd(0, 1, 0, 32'h800, 12, 3, 0, 9, 0, "R9");           // fault at element 9
        run_cmd(0, 0, 1, 32'h900, 13, 0, 0, -1, 1, "R12");         // start while busy
        run_cmd(0, 7, 3, 32'hA00, 30, 0, 0, -1, 0, "R13");         // vl ignored, wraps
        run_cmd(0, 0, 0, 32'hB00, 5, 0, 200, -1, 0, "R13");

        // Random commands
        for (int i = 0; i < 40; i++) begin
            int mode, nf, eew, vs, vl, tot, fa;
            logic [31:0] base;
            mode = $urandom % 4;
            nf   = $urandom % 8;
            eew  = $urandom % 4;
            vl   = $urandom % (VLEN + 1);
            base = $urandom & 32'hFFFF_FFF8;
            if ($urandom % 8 == 0) base = base | 32'h2;
            tot  = legal_of(mode, nf) ? total_of(mode, nf, eew, vl) : 8;
            vs   = ($urandom % 3 == 0) ? int'($urandom % (tot + 3)) : 0;
            fa   = ($urandom % 5 == 0) ? int'($urandom % (tot + 1)) : -1;
            run_cmd(mode, nf, eew, base, $urandom % 32, vs, vl, fa, 0, "R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule